// File: doc/BRIEF.md
# Configurable-Word SPI Master

This block is a single-channel SPI master. One packed 32-bit configuration word selects the transfer length, the SCLK divider, the chip-select pattern and the mode flags. A write to the data register loads a 32-bit shift register and starts a transfer. The block drives MOSI from one end of the shift register and samples MISO into the other end. Once busy drops, the received word can be read back from the same register.

Writes reach the block on a strobe/address/data port, where address 0 is the configuration word and address 1 is the data register. A write is taken only when no transfer is running. Any write made while a transfer runs is discarded and produces a one-cycle error pulse.

If the end flag is clear, chip select stays asserted after the transfer and the block waits for further writes. This lets several words form one transaction without chip select being released between them.

Top module: `spi_word_master`

## Requirements
- R1: After reset, busy and the error pulse are 0, csN is all ones, SCLK and MOSI are 0, and the read data is 0. The reset configuration gives a length of 1 bit, a divider of 2 and a chip-select pattern of 0.
- R2: The configuration word is split into fields by bit position:
  - bits 31:24 hold the chip-select pattern;
  - bits 23:16 hold the divider minus 2, giving a divider of 2 to 257;
  - bits 15:8 hold the length minus 1, where any value above 31 is treated as 31, so the length is 1 to 32;
  - bits 7:0 hold the flags: bit 0 end, bit 1 clock phase, bit 2 clock polarity, bit 3 LSB-first.
- R3: An accepted data write raises busy in the next cycle. Busy then stays high for exactly (n+1)·div cycles, where n is the length.
- R4: A transfer begins with one lead-in period of div cycles in which SCLK is idle. Each of the n bit periods that follow lasts div cycles, split into a setup phase of ceil(div/2) cycles and a hold phase of floor(div/2) cycles. SCLK idles at the polarity flag. With the phase flag at 0, SCLK is active (inverted) in the hold phase; with the phase flag at 1, it is active in the setup phase.
- R5: With LSB-first clear, MOSI carries bit 31 of the shift register. Each bit period shifts the register left and inserts the received bit at bit 0. After n bits the read data is the loaded word rotated left by n.
- R6: With LSB-first set, MOSI carries bit 0. Each bit period shifts the register right and inserts the received bit at bit 31. After n bits the read data is the loaded word rotated right by n.
- R7: MISO is sampled on the last cycle of each setup phase.
- R8: csN equals the inverted chip-select pattern from the cycle after the data write, and stays at that value throughout the transfer. When busy drops, csN returns to all ones if the end flag is set and stays asserted otherwise.
- R9: A write of either address while busy is discarded, and the error output is high for exactly the next cycle. The configuration and the data transfer in progress are left unchanged.
- R10: While chip select is held with busy low, configuration and data writes are accepted. A data write there starts the next transfer without releasing chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Write strobe |
| wrAddr | input | 1 | 0 = configuration word, 1 = data register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Shift register contents (received word after a transfer) |
| busy | output | 1 | Transfer in progress |
| busyErr | output | 1 | One-cycle pulse after a write made while busy |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 8 | Active-low chip selects |

## Verification
A wrong divider or bit counter changes the number of cycles busy stays high, so it is visible as soon as that transfer ends. A misplaced setup/hold split changes how many cycles SCLK spends away from its idle level, and this shows up on every odd divider. A wrong shift direction or a wrong sample instant corrupts the rotated word that is read back right after busy falls. The sample instant is caught with a slave that drives MISO differently in the setup and hold phases. A lost or wrongly timed chip-select state shows on csN in the first cycle after busy falls.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int CFG_W   = 32;
  localparam int CS_W    = 8;
  localparam int FIELD_W = 8;

  localparam int FLAG_END  = 0;
  localparam int FLAG_CPHA = 1;
  localparam int FLAG_CPOL = 2;
  localparam int FLAG_LSB  = 3;

  typedef struct packed {
    logic [CS_W-1:0]    csPat;
    logic [FIELD_W-1:0] divM2;
    logic [FIELD_W-1:0] lenM1;
    logic [FIELD_W-1:0] flags;
  } cfg_t;

  typedef struct packed {
    logic cfgWr;
    logic dataWr;
    logic sample;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/spi_word_dp.sv
module spi_word_dp
  import spi_word_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output cfg_t              cfg,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] shiftQ;
  logic              rxBit;
  logic              lsbFirst;
  logic              unusedFlags;

  assign lsbFirst    = cfg.flags[FLAG_LSB];
  assign unusedFlags = ^cfg.flags[FIELD_W-1:FLAG_LSB+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (st.cfgWr) begin
      cfg <= cfg_t'(wrData[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftQ <= '0;
      rxBit  <= 1'b0;
    end else begin
      if (st.sample) rxBit <= miso;
      if (st.dataWr) begin
        shiftQ <= wrData;
      end else if (st.shift) begin
        if (lsbFirst) shiftQ <= {rxBit, shiftQ[DATA_W-1:1]};
        else          shiftQ <= {shiftQ[DATA_W-2:0], rxBit};
      end
    end
  end

  assign mosi   = lsbFirst ? shiftQ[0] : shiftQ[DATA_W-1];
  assign rdData = shiftQ;

  // R5: a load never collides with a shift of the running transfer
  assert_load_vs_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.dataWr && st.shift));
  // R7: the sample point lies strictly before the end of the bit period
  assert_sample_before_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.sample && st.shift));
endmodule

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl
  import spi_word_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrStb,
  input  logic            wrAddr,
  input  cfg_t            cfg,
  output strobe_t         st,
  output logic            busy,
  output logic            busyErr,
  output logic            sclk,
  output logic [CS_W-1:0] csN
);
  localparam int DIV_W = FIELD_W + 1;
  localparam int BIT_W = 6;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divVal;
  logic [DIV_W:0]   setupSum;
  logic [DIV_W-1:0] setupLen;
  logic [4:0]       lenM1Eff;
  logic [BIT_W-1:0] lastBit;
  logic             lastDiv;
  logic             inBit;
  logic             inHold;
  logic             accept;

  always_comb begin
    divVal   = {1'b0, cfg.divM2} + DIV_W'(2);
    setupSum = {1'b0, divVal} + (DIV_W+1)'(1);
    setupLen = setupSum[DIV_W:1];
    lenM1Eff = (cfg.lenM1 > 8'd31) ? 5'd31 : cfg.lenM1[4:0];
    lastBit  = {1'b0, lenM1Eff} + BIT_W'(1);
    lastDiv  = (divCnt == divVal - DIV_W'(1));
    inBit    = (state == S_XFER) && (bitCnt != '0);
    inHold   = (divCnt >= setupLen);
    accept   = wrStb && (state != S_XFER);

    st.cfgWr  = accept && !wrAddr;
    st.dataWr = accept && wrAddr;
    st.sample = inBit && (divCnt == setupLen - DIV_W'(1));
    st.shift  = inBit && lastDiv;

    busy = (state == S_XFER);
    sclk = cfg.flags[FLAG_CPOL] ^
           (inBit && (cfg.flags[FLAG_CPHA] ? !inHold : inHold));
    csN  = (state == S_IDLE) ? '1 : ~cfg.csPat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      busyErr <= 1'b0;
    end else begin
      busyErr <= wrStb && (state == S_XFER);
      case (state)
        S_XFER: begin
          if (lastDiv) begin
            divCnt <= '0;
            if (bitCnt == lastBit) begin
              state <= cfg.flags[FLAG_END] ? S_IDLE : S_HOLD;
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: begin
          if (st.dataWr) begin
            state  <= S_XFER;
            divCnt <= '0;
            bitCnt <= '0;
          end
        end
      endcase
    end
  end

  // Independent cycle count of each transfer, used by the duration check.
  logic [CYC_W-1:0] cycCnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         cycCnt <= '0;
    else if (st.dataWr) cycCnt <= '0;
    else if (busy)      cycCnt <= cycCnt + CYC_W'(1);
  end

  assert_xfer_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cycCnt == CYC_W'(({1'b0, lenM1Eff} + 6'd2) * divVal)));
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStb && busy) |=> busyErr);
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busyErr |-> $past(wrStb && busy));
  assert_cs_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(csN));
  assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cfg.flags[FLAG_END]) |-> (csN == '1));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStb,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              busyErr,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   csN
);
  strobe_t st;
  cfg_t    cfg;

  spi_word_ctrl #(.CYC_W(16)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrAddr(wrAddr), .cfg(cfg),
    .st(st), .busy(busy), .busyErr(busyErr), .sclk(sclk), .csN(csN)
  );

  spi_word_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData), .miso(miso),
    .cfg(cfg), .mosi(mosi), .rdData(rdData)
  );
endmodule

// File: tb/spi_word_master_tb.sv
`timescale 1ns/1ps
module spi_word_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrStb = 1'b0;
  logic        wrAddr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        busy, busyErr, sclk, mosi, miso;
  logic [7:0]  csN;

  logic        misoMode = 1'b0;
  logic        cpolExp = 1'b0;
  logic        endExp = 1'b1;
  logic [7:0]  csExp = 8'h00;
  int busyCnt = 0, actCnt = 0, csBad = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_word_master u_dut (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdData(rdData), .busy(busy), .busyErr(busyErr), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  // Loopback slave, or a slave driving 1 while SCLK is idle (sample-point probe).
  assign miso = misoMode ? (sclk == cpolExp) : mosi;

  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (busy && (sclk != cpolExp)) actCnt++;
    if (busy && (csN != ~csExp)) csBad++;
  end

  // {flags, length, divider, cs, data}
  localparam logic [71:0] VECS [6] = '{
    {8'h01, 8'd32, 16'd2,   8'h01, 32'hA5C31E0F},
    {8'h09, 8'd32, 16'd3,   8'h02, 32'h12345678},
    {8'h03, 8'd8,  16'd5,   8'h80, 32'hDEADBEEF},
    {8'h0D, 8'd13, 16'd4,   8'h0F, 32'h0F0F3C3C},
    {8'h07, 8'd1,  16'd7,   8'h40, 32'h80000001},
    {8'h01, 8'd32, 16'd257, 8'h01, 32'h0000FFFF}
  };

  function automatic logic [31:0] rotl(logic [31:0] v, int n);
    logic [63:0] t;
    t = {v, v} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] rotr(logic [31:0] v, int n);
    logic [63:0] t;
    t = {v, v} >> n;
    return t[31:0];
  endfunction

  function automatic logic [31:0] cfgWord(logic [7:0] f, int len, int dv, logic [7:0] cs);
    return {cs, 8'(dv - 2), 8'(len - 1), f};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] w);
    @(negedge clk); wrStb = 1'b1; wrAddr = 1'b0; wrData = w;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic doXfer(input logic [31:0] d, input int expBusy, input int expAct,
                        input logic [31:0] expRd, input string rdTag);
    int b0, a0, c0;
    @(negedge clk); wrStb = 1'b1; wrAddr = 1'b1; wrData = d;
    b0 = busyCnt; a0 = actCnt; c0 = csBad;
    @(negedge clk); wrStb = 1'b0;
    while (busy) @(negedge clk);
    #1;
    chk(busyCnt - b0 == expBusy, "R3 busy length", busyCnt - b0, expBusy);
    chk(actCnt - a0 == expAct, "R4 sclk active cycles", actCnt - a0, expAct);
    chk(csBad == c0, "R8 cs during transfer", csBad - c0, 0);
    chk(rdData == expRd, rdTag, rdData, expRd);
    chk(csN == (endExp ? 8'hFF : ~csExp), "R8 cs after transfer", csN, endExp ? 8'hFF : ~csExp);
    chk(sclk == cpolExp, "R4 sclk idle level", sclk, cpolExp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(busyErr == 1'b0, "R1 busyErr", busyErr, 0);
    chk(csN == 8'hFF, "R1 csN", csN, 8'hFF);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
    chk(rdData == 32'h0, "R1 rdData", rdData, 0);
    // R1 default config: 1 bit, div 2, cs 0
    doXfer(32'h80000000, 4, 1, 32'h00000001, "R1 default config R5");

    // Table of vectors
    for (int i = 0; i < 6; i++) begin
      logic [7:0] f; int len, dv; logic [31:0] d, er; int ea;
      f = VECS[i][71:64]; len = int'(VECS[i][63:56]); dv = int'(VECS[i][55:40]);
      d = VECS[i][31:0];
      csExp = VECS[i][39:32]; cpolExp = f[2]; endExp = f[0];
      writeCfg(cfgWord(f, len, dv, VECS[i][39:32]));
      er = f[3] ? rotr(d, len) : rotl(d, len);
      ea = len * (f[1] ? (dv + 1) / 2 : dv / 2);
      doXfer(d, (len + 1) * dv, ea, er, f[3] ? "R6 lsb-first data" : "R5 msb-first data");
    end

    // R2 length field above 31 saturates to 32 bits
    csExp = 8'h01; cpolExp = 1'b0; endExp = 1'b1;
    writeCfg({8'h01, 8'd0, 8'd200, 8'h01});
    doXfer(32'hC0FFEE11, 66, 32, 32'hC0FFEE11, "R2 length saturation");

    // R7 sample point: miso is 1 in setup (sclk idle), 0 in hold
    misoMode = 1'b1;
    writeCfg(cfgWord(8'h01, 8, 4, 8'h01));
    doXfer(32'h0, 36, 16, 32'h000000FF, "R7 miso sample point");
    misoMode = 1'b0;

    // R9 writes while busy are dropped with an error pulse
    begin
      int b0;
      writeCfg(cfgWord(8'h01, 16, 2, 8'h01));
      @(negedge clk); wrStb = 1'b1; wrAddr = 1'b1; wrData = 32'h3C5A_9617;
      b0 = busyCnt;
      @(negedge clk); wrAddr = 1'b0; wrData = cfgWord(8'h0F, 1, 2, 8'hF0);
      @(negedge clk); wrStb = 1'b0; #1;
      chk(busyErr == 1'b1, "R9 error pulse on config write", busyErr, 1);
      @(negedge clk); #1;
      chk(busyErr == 1'b0, "R9 error pulse one cycle", busyErr, 0);
      @(negedge clk); wrStb = 1'b1; wrAddr = 1'b1; wrData = 32'h0;
      @(negedge clk); wrStb = 1'b0; #1;
      chk(busyErr == 1'b1, "R9 error pulse on data write", busyErr, 1);
      while (busy) @(negedge clk);
      #1;
      chk(busyCnt - b0 == 34, "R9 config unchanged", busyCnt - b0, 34);
      chk(rdData == rotl(32'h3C5A_9617, 16), "R9 data write dropped", rdData, rotl(32'h3C5A_9617, 16));
      chk(csN == 8'hFF, "R9 cs pattern unchanged", csN, 8'hFF);
    end

    // R10 / R8 chained words under one chip select
    csExp = 8'h03; cpolExp = 1'b0; endExp = 1'b0;
    writeCfg(cfgWord(8'h00, 8, 2, 8'h03));
    doXfer(32'hC3000000, 18, 8, 32'h000000C3, "R5 first chained word");
    repeat (3) @(negedge clk);
    #1;
    chk(csN == 8'hFC, "R8 cs held without end flag", csN, 8'hFC);
    writeCfg(cfgWord(8'h01, 8, 2, 8'h03));
    #1;
    chk(busyErr == 1'b0 && csN == 8'hFC, "R10 config accepted while held", {busyErr, csN}, 8'hFC);
    endExp = 1'b1;
    doXfer(32'h5A000000, 18, 8, 32'h0000005A, "R10 second chained word");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule